// File: doc/BRIEF.md
# SPI Byte Transceiver (Master or Slave)

This block is a full-duplex serial peripheral port. It exchanges one byte per transfer over a clock, data-in and data-out line pair, with an optional active-low select input. Software drives it through a small register bus. It can act as the clock-driving master, or as a slave that follows an external clock. A single shift register moves the outgoing byte out and the incoming byte in at the same time, most significant bit first. A separate holding register keeps the last received byte, so the next byte can start shifting before software collects the previous one.

In master mode a write to the data register starts a transfer. The serial clock runs at one of three fixed fractions of the system clock, or at half the rate of an external timer tick. In slave mode the external clock is synchronised into the system clock domain and its edges drive the shift register. A completed byte sets a buffer-full flag and a sticky interrupt flag in the same cycle. A data write while a byte is moving is dropped and raises a sticky collision flag.

Top module: `spi_xcvr`

## Requirements
- R1: A master transfer shifts the written byte out on `sdo` most significant bit first while shifting 8 bits in from `sdi`, and the received byte is then read back from the data register (address 0).
- R2: A master transfer makes exactly 16 transitions on `sck_out` and leaves it at the idle level given by the polarity bit (control bit 4, address 1). The busy bit (status bit 2, address 2) is 0 once the transfer is over.
- R3: With the edge bit (control bit 5) at 0, `sdi` is sampled on the edge leaving idle, `sdo` changes on the edge returning to idle, and the first bit is on `sdo` before the first edge. With it at 1, `sdo` changes on the edge leaving idle and `sdi` is sampled on the edge returning to idle.
- R4: The mode field (control bits 3:0) sets the master half period. Codes 0, 1 and 2 give 2, 8 and 32 system clocks (division by 4, 16 and 64 with the default base). Code 3 gives one half period per `tmr_tick` pulse.
- R5: Mode codes 4 and 5 select slave mode. The byte is shifted on edges of `sck_in` and the written byte appears on `sdo` in the same bit order and edge scheme as R3.
- R6: In mode 4, while `ss_n` is high, `sdo_oe` is 0, clock edges are ignored and the bit counter is cleared. In mode 5, `ss_n` has no effect.
- R7: When the 8th bit is sampled, the received byte is loaded into the holding register. In the same cycle the full bit (status bit 0) and the interrupt bit (status bit 1, also the `irq` pin) are set.
- R8: While a new byte is shifting, a read of the data register still returns the previously received byte.
- R9: A data write during a transfer leaves the outgoing byte unchanged and sets the collision bit (control bit 7). That bit stays set until a control write with bit 7 at 0.
- R10: A read of the data register clears the full bit.
- R11: The interrupt bit stays set after the data is read. It clears only on a status write with bit 1 at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle (side effects) |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| tmr_tick | input | 1 | Timer pulse used by mode 3 |
| sck_in | input | 1 | Serial clock in slave mode |
| sck_out | output | 1 | Serial clock driven in master mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| ss_n | input | 1 | Active-low slave select |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The master path is run over every rate code, both polarities and both edge schemes, each with a different outgoing and incoming byte. Bit-order errors, a swapped sampling edge and a wrong divider each produce a distinct mismatch in the captured byte or in the measured half period. The slave path is driven by a bench-generated clock for each polarity and edge combination with the select line held high, which separates the mode that honours select from the one that ignores it. Dedicated runs place a data write in mid-transfer, a data read between two back-to-back receptions, and a partial byte cut off by the select line. These show that dropped writes, double buffering and counter clearing each behave independently.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  localparam logic [3:0] MODE_SLV_SEL  = 4'd4;
  localparam logic [3:0] MODE_SLV_FREE = 4'd5;

  typedef struct packed {
    logic       en;
    logic       out_late;
    logic       cpol;
    logic [3:0] mode;
  } ctrl_t;

  function automatic logic mode_is_master(input logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction

  function automatic logic mode_is_slave(input logic [3:0] m);
    return (m == MODE_SLV_SEL) || (m == MODE_SLV_FREE);
  endfunction

  // system clocks per serial half period for fixed rates 0..2
  function automatic int unsigned half_period(input logic [1:0] rate, input int unsigned base);
    return (base << (2 * int'(rate))) >> 1;
  endfunction

endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[i]}};
      else        st <= {st[0], d[i]};
    end
    assign q[i] = st[1];
  end
endmodule

// File: rtl/spi_xcvr_clkgen.sv
module spi_xcvr_clkgen #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       tmr_tick,
  output logic       half_tick
);
  import spi_xcvr_pkg::*;

  localparam int unsigned MAX_HALF = half_period(2'd2, BASE_DIV);
  localparam int          CW       = $clog2(MAX_HALF) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          at_lim;
  logic          use_tmr;

  always_comb begin
    use_tmr   = (rate == 2'd3);
    lim       = CW'(half_period(rate, BASE_DIV) - 1);
    at_lim    = (cnt_q == lim);
    half_tick = run && (use_tmr ? tmr_tick : at_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (!run || at_lim || use_tmr) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_xcvr_shifter.sv
module spi_xcvr_shifter #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DW-1:0]         load_byte,
  input  logic                  out_late,
  input  logic                  ev_lead,
  input  logic                  ev_trail,
  input  logic                  clr_cnt,
  input  logic                  sdi_bit,
  output logic [DW-1:0]         rx_next,
  output logic                  sdo_bit,
  output logic [$clog2(DW)-1:0] bit_cnt,
  output logic                  ev_sample,
  output logic                  ev_drive,
  output logic                  ev_done
);
  localparam int                CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DW - 1);

  logic [DW-1:0]    sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sdo_q;

  always_comb begin
    ev_sample = out_late ? ev_trail : ev_lead;
    ev_drive  = out_late ? ev_lead  : ev_trail;
    ev_done   = ev_sample && !clr_cnt && (cnt_q == LAST);
    rx_next   = {sr_q[DW-2:0], sdi_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (load) begin
      sr_q  <= load_byte;
      cnt_q <= '0;
      if (!out_late) sdo_q <= load_byte[DW-1];
    end else if (clr_cnt) begin
      cnt_q <= '0;
    end else begin
      if (ev_sample) begin
        sr_q  <= rx_next;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (ev_drive && (out_late || cnt_q != '0)) sdo_q <= sr_q[DW-1];
    end
  end

  assign sdo_bit = sdo_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr #(
  parameter int          DW       = 8,
  parameter int unsigned BASE_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_tick,
  input  logic          sck_in,
  output logic          sck_out,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          ss_n,
  output logic          irq
);
  import spi_xcvr_pkg::*;

  localparam int             HW        = $clog2(2 * DW);
  localparam logic [HW-1:0]  LAST_HALF = HW'(2 * DW - 1);
  localparam logic [1:0]     A_DATA    = 2'd0;
  localparam logic [1:0]     A_CTRL    = 2'd1;
  localparam logic [1:0]     A_STAT    = 2'd2;

  ctrl_t            ctrl_q;
  logic             wcol_q, full_q, irq_q, m_busy, sck_q, sck_d;
  logic [DW-1:0]    hold_q;
  logic [HW-1:0]    half_q;
  logic [2:0]       pin_s;
  logic             ss_s, sdi_s, sck_s;
  logic             is_master, is_slave, ss_block, slave_run, cpol;
  logic             half_tick, m_lead, m_trail, s_lead, s_trail;
  logic             data_wr, data_rd, ctrl_wr, stat_wr, xfer_busy;
  logic             wr_collide, wr_load, m_start, irq_clr, sdi_bit;
  logic [DW-1:0]    rx_next;
  logic [$clog2(DW)-1:0] bit_cnt;
  logic             ev_sample, ev_drive, ev_done, sdo_bit;

  spi_xcvr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, sdi, sck_in}), .q(pin_s));

  assign {ss_s, sdi_s, sck_s} = pin_s;

  always_comb begin
    cpol       = ctrl_q.cpol;
    is_master  = mode_is_master(ctrl_q.mode);
    is_slave   = mode_is_slave(ctrl_q.mode);
    ss_block   = is_slave && (ctrl_q.mode == MODE_SLV_SEL) && ss_s;
    slave_run  = ctrl_q.en && is_slave && !ss_block;
    m_lead     = half_tick && (sck_q == cpol);
    m_trail    = half_tick && (sck_q != cpol);
    s_lead     = slave_run && (cpol ? (!sck_s && sck_d) : (sck_s && !sck_d));
    s_trail    = slave_run && (cpol ? (sck_s && !sck_d) : (!sck_s && sck_d));
    sdi_bit    = is_master ? sdi : sdi_s;
    data_wr    = bus_wr && (bus_addr == A_DATA);
    ctrl_wr    = bus_wr && (bus_addr == A_CTRL);
    stat_wr    = bus_wr && (bus_addr == A_STAT);
    data_rd    = bus_rd && (bus_addr == A_DATA);
    xfer_busy  = m_busy || (is_slave && bit_cnt != '0);
    wr_collide = data_wr && xfer_busy;
    wr_load    = data_wr && !xfer_busy;
    m_start    = wr_load && is_master && ctrl_q.en;
    irq_clr    = stat_wr && !bus_wdata[1];
  end

  spi_xcvr_clkgen #(.BASE_DIV(BASE_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(m_busy), .rate(ctrl_q.mode[1:0]),
    .tmr_tick(tmr_tick), .half_tick(half_tick));

  spi_xcvr_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .load_byte(bus_wdata),
    .out_late(ctrl_q.out_late), .ev_lead(m_lead || s_lead),
    .ev_trail(m_trail || s_trail), .clr_cnt(ss_block), .sdi_bit(sdi_bit),
    .rx_next(rx_next), .sdo_bit(sdo_bit), .bit_cnt(bit_cnt),
    .ev_sample(ev_sample), .ev_drive(ev_drive), .ev_done(ev_done));

  // master clock sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
      half_q <= '0;
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (m_start) begin
        m_busy <= 1'b1;
        half_q <= '0;
        sck_q  <= cpol;
      end else if (m_busy) begin
        if (half_tick) begin
          sck_q  <= ~sck_q;
          half_q <= half_q + 1'b1;
          if (half_q == LAST_HALF) m_busy <= 1'b0;
        end
      end else begin
        sck_q <= cpol;
      end
    end
  end

  // register file and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wcol_q <= 1'b0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[6:0]);
      if (wr_collide)                  wcol_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[7]) wcol_q <= 1'b0;
      if (ev_done) begin
        hold_q <= rx_next;
        full_q <= 1'b1;
        irq_q  <= 1'b1;
      end else begin
        if (data_rd) full_q <= 1'b0;
        if (irq_clr) irq_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = hold_q;
      A_CTRL:  bus_rdata = DW'({wcol_q, ctrl_q});
      A_STAT:  bus_rdata = DW'({xfer_busy, irq_q, full_q});
      default: bus_rdata = '0;
    endcase
  end

  assign sck_out = sck_q;
  assign sdo     = sdo_bit;
  assign sdo_oe  = ctrl_q.en && (is_master || (is_slave && !ss_block));
  assign irq     = irq_q;

endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ev_done,
  input logic                  full_q,
  input logic                  irq_q,
  input logic                  data_rd,
  input logic                  wr_collide,
  input logic                  wcol_q,
  input logic                  m_busy,
  input logic                  sck_q,
  input logic                  cpol,
  input logic                  ss_block,
  input logic [$clog2(DW)-1:0] bit_cnt,
  input logic                  irq_clr
);
  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (full_q && irq_q));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ev_done) |=> !full_q);

  // R9
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |=> wcol_q);

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_busy) |-> (sck_q == cpol));

  // R6
  ss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_block |=> (bit_cnt == '0));

  // R11
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !ev_done) |=> !irq_q);
endmodule

bind spi_xcvr spi_xcvr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .full_q(full_q), .irq_q(irq_q),
  .data_rd(data_rd), .wr_collide(wr_collide), .wcol_q(wcol_q), .m_busy(m_busy),
  .sck_q(sck_q), .cpol(cpol), .ss_block(ss_block), .bit_cnt(bit_cnt),
  .irq_clr(irq_clr));

// File: tb/spi_xcvr_tb.sv
`timescale 1ns/1ps
module spi_xcvr_tb;
  localparam int DW       = 8;
  localparam int TICK_GAP = 3;
  localparam int SH       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic tmr_tick = 1'b0, sck_in = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic sck_out, sdo, sdo_oe, irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  spi_xcvr #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_tick(tmr_tick),
    .sck_in(sck_in), .sck_out(sck_out), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .ss_n(ss_n), .irq(irq));

  initial begin
    forever begin
      repeat (TICK_GAP - 1) @(negedge clk);
      tmr_tick = 1'b1;
      @(negedge clk);
      tmr_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int half_expect(input int mode);
    return (mode < 3) ? ((4 << (2 * mode)) / 2) : TICK_GAP;
  endfunction

  function automatic logic [7:0] ctrl_word(input int mode, input bit cpol, input bit late, input bit en);
    return {1'b0, en, late, cpol, 4'(mode)};
  endfunction

  // inject: 0 none, 1 data write mid-transfer, 2 data read mid-transfer
  task automatic master_xfer(input int mode, input bit cpol, input bit late,
                             input logic [7:0] tx, input logic [7:0] rx,
                             input int inject, input logic [7:0] alt, input bit final_read);
    logic [7:0] cap, r;
    int ntr, di, cyc, last_t, meas;
    logic prev;
    bit lead;
    cap = '0; ntr = 0; cyc = 0; last_t = 0; meas = -1;
    wr(2'd1, ctrl_word(mode, cpol, late, 1'b1));
    if (!late) begin sdi = rx[7]; di = 1; end
    else di = 0;
    prev = cpol;
    wr(2'd0, tx);
    while (ntr < 16 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (sck_out !== prev) begin
        lead = (sck_out != cpol);
        ntr++;
        prev = sck_out;
        if (ntr == 3) meas = cyc - last_t;
        last_t = cyc;
        if (lead != late) cap = {cap[6:0], sdo};
        else if (di < 8) begin sdi = rx[7 - di]; di++; end
        if (ntr == 4 && inject == 1) wr(2'd0, alt);
        if (ntr == 6 && inject == 2) begin
          rd(2'd0, r);
          chk("R8 previous byte held during next transfer", r, alt);
        end
      end
    end
    repeat (4) @(negedge clk);
    chk("R2 transition count", ntr, 16);
    chk("R1 R3 tx byte on sdo", cap, tx);
    chk("R4 half period", meas, half_expect(mode));
    chk("R2 idle level", sck_out, cpol);
    rd(2'd2, r);
    chk("R7 full set", r[0], 1);
    chk("R7 irq set", r[1], 1);
    chk("R2 busy clear", r[2], 0);
    if (final_read) begin
      rd(2'd0, r);
      chk("R1 rx byte", r, rx);
      rd(2'd2, r);
      chk("R10 full cleared by read", r[0], 0);
      chk("R11 irq sticky after read", irq, 1);
      wr(2'd2, 8'h00);
      rd(2'd2, r);
      chk("R11 irq cleared by write", r[1], 0);
    end
  endtask

  task automatic slave_xfer(input int mode, input bit cpol, input bit late,
                            input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] cap, r;
    cap = '0;
    wr(2'd1, ctrl_word(mode, cpol, late, 1'b0));
    sck_in = cpol;
    repeat (4) @(negedge clk);
    wr(2'd1, ctrl_word(mode, cpol, late, 1'b1));
    wr(2'd0, tx);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!late) begin
        sdi = rx[7 - i];
        repeat (SH) @(negedge clk);
        cap = {cap[6:0], sdo};
        sck_in = ~cpol;
        repeat (SH) @(negedge clk);
        sck_in = cpol;
      end else begin
        sck_in = ~cpol;
        sdi = rx[7 - i];
        repeat (SH) @(negedge clk);
        cap = {cap[6:0], sdo};
        sck_in = cpol;
        repeat (SH) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    chk("R5 slave tx byte", cap, tx);
    rd(2'd2, r);
    chk("R7 slave full set", r[0], 1);
    rd(2'd0, r);
    chk("R5 slave rx byte", r, rx);
    wr(2'd2, 8'h00);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck_in = 1'b1;
      repeat (SH) @(negedge clk);
      sck_in = 1'b0;
      repeat (SH) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd1, r);
    chk("R9 reset control", r, 0);
    rd(2'd2, r);
    chk("R7 reset status", r, 0);
    chk("R6 reset sdo_oe", sdo_oe, 0);
    chk("R11 reset irq", irq, 0);

    idx = 0;
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 2; e++) begin
          master_xfer(m, p[0], e[0], 8'(8'hA5 ^ (idx * 37)), 8'(8'h3C + idx * 53), 0, 8'h00, 1'b1);
          idx++;
        end

    master_xfer(2, 1'b0, 1'b0, 8'h81, 8'h17, 1, 8'h5A, 1'b1);
    rd(2'd1, r);
    chk("R9 collision flag set", r[7], 1);
    wr(2'd1, ctrl_word(2, 1'b0, 1'b0, 1'b1) | 8'h80);
    rd(2'd1, r);
    chk("R9 collision sticky on write of 1", r[7], 1);
    wr(2'd1, ctrl_word(2, 1'b0, 1'b0, 1'b1));
    rd(2'd1, r);
    chk("R9 collision cleared", r[7], 0);

    master_xfer(2, 1'b1, 1'b0, 8'h11, 8'h6E, 0, 8'h00, 1'b0);
    master_xfer(2, 1'b1, 1'b1, 8'h22, 8'h93, 2, 8'h6E, 1'b1);

    ss_n = 1'b1;
    idx = 0;
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 2; e++) begin
        slave_xfer(5, p[0], e[0], 8'(8'hC6 + idx * 29), 8'(8'h59 ^ (idx * 71)));
        idx++;
      end

    ss_n = 1'b0;
    slave_xfer(4, 1'b0, 1'b0, 8'hB4, 8'h2D);

    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 sdo_oe off while deselected", sdo_oe, 0);
    pulses(8);
    repeat (4) @(negedge clk);
    rd(2'd2, r);
    chk("R6 edges ignored while deselected", r[0], 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 sdo_oe on while selected", sdo_oe, 1);
    pulses(3);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    slave_xfer(4, 1'b0, 1'b0, 8'hC3, 8'hE1);
    rd(2'd1, r);
    chk("R6 counter cleared so no collision", r[7], 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule